// File: doc/BRIEF.md
# Cascaded Interrupt Controller

The block merges up to fifteen device interrupt lines into one request to a processor. It is built from two eight-line units. The primary unit talks to the processor. The secondary unit's output enters the primary unit in place of primary line 2. Each unit catches rising edges on its lines and holds them as pending requests. Lines can be blocked with a per-unit mask. Each unit forms a vector by adding its own programmable base to the number of the winning line.

Software programs each unit through a small write port: a base write, a mask write and an end-of-interrupt write. A unit is armed only when its base has been written. Nothing reaches the processor until both units are armed. While the request output is high, the vector output shows the vector that would be taken. The processor takes the interrupt by holding the acknowledge input high at a clock edge. The winning line then moves to the in-service state. That unit stays silent until software ends the interrupt. For an interrupt from the secondary unit, the interrupt must be ended at both units.

Top module: `irq_cascade`

## Requirements
- R1: After reset, intReq is low, every line of both units is masked, both bases are zero and neither unit is armed.
- R2: intReq stays low until the base register of the primary unit and the base register of the secondary unit have each been written at least once since reset.
- R3: A rising edge that arrives on a line while that line's mask bit is 1 is discarded. Writing a mask also clears any request already pending on each line whose new mask bit is 1.
- R4: A request is latched on a rising edge only. A line held high requests once. After an acknowledge, intReq stays low as long as any in-service bit of the primary unit is set. An end-of-interrupt write clears all of a unit's in-service bits.
- R5: When the secondary unit has any in-service bit set, intReq stays low. An interrupt from the secondary unit therefore needs end-of-interrupt at both units, in either order, before anything is delivered again.
- R6: While intReq is high, vector equals base plus line number, taken modulo 256, of the winning unit. An acknowledge is the cycle in which intAck is 1 at a rising clock edge while intReq is 1.
- R7: Within a unit, the lowest-numbered pending unmasked line wins. The whole secondary unit competes at the priority of primary line 2, and primary bit 2 of the mask blocks all secondary lines.
- R8: Input irqIn[2] is ignored. Lines irqIn[7:0] go to the primary unit (bit n is line n). Lines irqIn[15:8] go to the secondary unit (bit 8+n is line n).
- R9: A write happens in the cycle in which wrEn is 1. wrUnit 0 selects the primary unit and 1 selects the secondary unit. wrSel 0 writes the base and arms the unit. wrSel 1 writes the mask, where bit n = 1 masks line n. wrSel 2 is end-of-interrupt. wrSel 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Device lines; [7:0] primary, [15:8] secondary, bit 2 unused |
| wrEn | input | 1 | Register write strobe |
| wrUnit | input | 1 | Unit select for the write: 0 primary, 1 secondary |
| wrSel | input | 2 | Register select: 0 base, 1 mask, 2 end-of-interrupt, 3 none |
| wrData | input | 8 | Write data |
| intAck | input | 1 | Processor takes the offered interrupt |
| intReq | output | 1 | Interrupt request to the processor |
| vector | output | 8 | Vector of the offered interrupt |

## Verification
The bench builds the block with its default parameters: eight lines per unit, an 8-bit vector and the cascade on primary line 2. With these values, random toggling of sixteen input bits covers every line, the unused cascade input slot and the priority contest between primary and secondary lines. With an 8-bit vector, a base near 255 makes the wrap-around of base plus line number visible. Directed steps cover arming order, masked edges, level-held lines and both orders of the two end-of-interrupt writes.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

  // Per-unit strobes from control to datapath
  typedef struct packed {
    logic offsetWr;
    logic maskWr;
    logic eoi;
    logic take;
  } unitStrobe_t;

  localparam logic [1:0] SEL_OFFSET = 2'd0;
  localparam logic [1:0] SEL_MASK   = 2'd1;
  localparam logic [1:0] SEL_EOI    = 2'd2;

endpackage

// File: rtl/pic_unit.sv
module pic_unit
  import irq_cascade_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter logic [LINES-1:0] CASC_MASK = '0,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  lines,
  input  logic              cascIn,
  input  unitStrobe_t       strb,
  input  logic [VEC_W-1:0]  wrData,
  input  logic              extBusy,
  output logic              deliver,
  output logic [IDX_W-1:0]  winner,
  output logic [VEC_W-1:0]  vector,
  output logic [LINES-1:0]  isrOut,
  output logic              armedOut
);

  logic [LINES-1:0] maskQ, reqQ, isrQ, prevQ;
  logic [VEC_W-1:0] offQ;
  logic             armedQ;

  logic [LINES-1:0] rawLines, rise, effReq, winBit, reqNext, isrNext;

  // Cascade slots take the level of the lower unit instead of an edge
  assign rawLines = lines & ~CASC_MASK;
  assign rise     = rawLines & ~prevQ;
  assign effReq   = ((reqQ & ~CASC_MASK) | (CASC_MASK & {LINES{cascIn}})) & ~maskQ;
  assign winBit   = effReq & (~effReq + LINES'(1));

  always_comb begin
    winner = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (effReq[i]) winner = IDX_W'(i);
    end
  end

  always_comb begin
    reqNext = reqQ | (rise & ~maskQ);
    if (strb.take)   reqNext = reqNext & ~winBit;
    if (strb.maskWr) reqNext = reqNext & ~wrData[LINES-1:0];
    isrNext = strb.eoi ? '0 : isrQ;
    if (strb.take)   isrNext = isrNext | winBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= '1;
      reqQ   <= '0;
      isrQ   <= '0;
      prevQ  <= '0;
      offQ   <= '0;
      armedQ <= 1'b0;
    end else begin
      prevQ <= rawLines;
      reqQ  <= reqNext;
      isrQ  <= isrNext;
      if (strb.maskWr) maskQ <= wrData[LINES-1:0];
      if (strb.offsetWr) begin
        offQ   <= wrData;
        armedQ <= 1'b1;
      end
    end
  end

  assign deliver  = armedQ & ~(|isrQ) & ~extBusy & (|effReq);
  assign vector   = offQ + VEC_W'(winner);
  assign isrOut   = isrQ;
  assign armedOut = armedQ;

endmodule

// File: rtl/irq_cascade_dp.sv
module irq_cascade_dp
  import irq_cascade_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*LINES-1:0] irqIn,
  input  logic [VEC_W-1:0]   wrData,
  input  unitStrobe_t        masterStrb,
  input  unitStrobe_t        slaveStrb,
  output logic               masterDeliver,
  output logic [IDX_W-1:0]   masterWinner,
  output logic               masterArmed,
  output logic               slaveArmed,
  output logic               slaveBusy,
  output logic [LINES-1:0]   masterIsr,
  output logic [VEC_W-1:0]   vector
);

  localparam logic [LINES-1:0] MASTER_CASC = LINES'(1) << CASC_LINE;

  logic               slaveDeliver;
  logic [IDX_W-1:0]   slaveWinner;
  logic [VEC_W-1:0]   masterVec, slaveVec;
  logic [LINES-1:0]   slaveIsr;

  pic_unit #(.LINES(LINES), .VEC_W(VEC_W), .CASC_MASK('0)) slaveU (
    .clk      (clk),
    .rstN     (rstN),
    .lines    (irqIn[2*LINES-1:LINES]),
    .cascIn   (1'b0),
    .strb     (slaveStrb),
    .wrData   (wrData),
    .extBusy  (1'b0),
    .deliver  (slaveDeliver),
    .winner   (slaveWinner),
    .vector   (slaveVec),
    .isrOut   (slaveIsr),
    .armedOut (slaveArmed)
  );

  assign slaveBusy = |slaveIsr;

  pic_unit #(.LINES(LINES), .VEC_W(VEC_W), .CASC_MASK(MASTER_CASC)) masterU (
    .clk      (clk),
    .rstN     (rstN),
    .lines    (irqIn[LINES-1:0]),
    .cascIn   (slaveDeliver),
    .strb     (masterStrb),
    .wrData   (wrData),
    .extBusy  (slaveBusy),
    .deliver  (masterDeliver),
    .winner   (masterWinner),
    .vector   (masterVec),
    .isrOut   (masterIsr),
    .armedOut (masterArmed)
  );

  assign vector = (masterWinner == IDX_W'(CASC_LINE)) ? slaveVec : masterVec;

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int LINES = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             wrEn,
  input  logic             wrUnit,
  input  logic [1:0]       wrSel,
  input  logic             intAck,
  input  logic             masterDeliver,
  input  logic             slaveArmed,
  input  logic [IDX_W-1:0] masterWinner,
  output unitStrobe_t      masterStrb,
  output unitStrobe_t      slaveStrb,
  output logic             intReq
);

  logic masterTake;

  assign intReq     = masterDeliver & slaveArmed;
  assign masterTake = intAck & intReq;

  always_comb begin
    masterStrb.offsetWr = wrEn & ~wrUnit & (wrSel == SEL_OFFSET);
    masterStrb.maskWr   = wrEn & ~wrUnit & (wrSel == SEL_MASK);
    masterStrb.eoi      = wrEn & ~wrUnit & (wrSel == SEL_EOI);
    masterStrb.take     = masterTake;
    slaveStrb.offsetWr  = wrEn & wrUnit & (wrSel == SEL_OFFSET);
    slaveStrb.maskWr    = wrEn & wrUnit & (wrSel == SEL_MASK);
    slaveStrb.eoi       = wrEn & wrUnit & (wrSel == SEL_EOI);
    slaveStrb.take      = masterTake & (masterWinner == IDX_W'(CASC_LINE));
  end

endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_cascade_pkg::*;
#(
  parameter int LINES = 8,
  parameter int VEC_W = 8,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2*LINES-1:0] irqIn,
  input  logic               wrEn,
  input  logic               wrUnit,
  input  logic [1:0]         wrSel,
  input  logic [VEC_W-1:0]   wrData,
  input  logic               intAck,
  output logic               intReq,
  output logic [VEC_W-1:0]   vector
);

  unitStrobe_t      masterStrb, slaveStrb;
  logic             masterDeliver, masterArmed, slaveArmed, slaveBusy;
  logic [IDX_W-1:0] masterWinner;
  logic [LINES-1:0] masterIsr;

  irq_cascade_ctrl #(.LINES(LINES), .CASC_LINE(CASC_LINE)) ctrlI (
    .wrEn          (wrEn),
    .wrUnit        (wrUnit),
    .wrSel         (wrSel),
    .intAck        (intAck),
    .masterDeliver (masterDeliver),
    .slaveArmed    (slaveArmed),
    .masterWinner  (masterWinner),
    .masterStrb    (masterStrb),
    .slaveStrb     (slaveStrb),
    .intReq        (intReq)
  );

  irq_cascade_dp #(.LINES(LINES), .VEC_W(VEC_W), .CASC_LINE(CASC_LINE)) dpI (
    .clk           (clk),
    .rstN          (rstN),
    .irqIn         (irqIn),
    .wrData        (wrData),
    .masterStrb    (masterStrb),
    .slaveStrb     (slaveStrb),
    .masterDeliver (masterDeliver),
    .masterWinner  (masterWinner),
    .masterArmed   (masterArmed),
    .slaveArmed    (slaveArmed),
    .slaveBusy     (slaveBusy),
    .masterIsr     (masterIsr),
    .vector        (vector)
  );

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk #(
  parameter int LINES = 8,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             intReq,
  input logic             intAck,
  input logic             wrEn,
  input logic             wrUnit,
  input logic [1:0]       wrSel,
  input logic [VEC_W-1:0] wrData,
  input logic             masterArmed,
  input logic             slaveArmed,
  input logic             slaveBusy,
  input logic [LINES-1:0] masterIsr
);

  // R2
  armed_before_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (masterArmed && slaveArmed));

  // R4
  ack_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> !intReq);

  // R4
  one_in_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(masterIsr));

  // R5
  slave_busy_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    slaveBusy |-> !intReq);

  // R3
  full_mask_silences_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrUnit && wrSel == 2'd1 && wrData[LINES-1:0] == '1) |=> !intReq);

endmodule

bind irq_cascade irq_cascade_chk #(.LINES(LINES), .VEC_W(VEC_W)) chkI (
  .clk         (clk),
  .rstN        (rstN),
  .intReq      (intReq),
  .intAck      (intAck),
  .wrEn        (wrEn),
  .wrUnit      (wrUnit),
  .wrSel       (wrSel),
  .wrData      (wrData),
  .masterArmed (masterArmed),
  .slaveArmed  (slaveArmed),
  .slaveBusy   (slaveBusy),
  .masterIsr   (masterIsr)
);

// File: tb/irq_cascade_test.sv
`timescale 1ns/1ps
module irq_cascade_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic        wrEn = 1'b0;
  logic        wrUnit = 1'b0;
  logic [1:0]  wrSel = 2'd3;
  logic [7:0]  wrData = '0;
  logic        intAck = 1'b0;
  logic        intReq;
  logic [7:0]  vector;

  int nChk = 0;
  int nFail = 0;
  logic [15:0] curLines = '0;

  // reference state, from the requirements
  logic [7:0] mMask[2], mOff[2], mReq[2], mIsr[2], mPrev[2];
  logic       mArm[2];

  irq_cascade uut (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .wrEn(wrEn), .wrUnit(wrUnit),
    .wrSel(wrSel), .wrData(wrData), .intAck(intAck), .intReq(intReq), .vector(vector)
  );

  always #4 clk = ~clk;

  function automatic int lowest(logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic logic slaveDel();
    return mArm[1] && (mIsr[1] == 0) && ((mReq[1] & ~mMask[1]) != 0);
  endfunction

  function automatic logic [7:0] eff0();
    logic [7:0] r;
    r = mReq[0];
    r[2] = slaveDel();
    return r & ~mMask[0];
  endfunction

  function automatic logic expReq();
    return mArm[0] && mArm[1] && (mIsr[0] == 0) && (mIsr[1] == 0) && (eff0() != 0);
  endfunction

  function automatic logic [7:0] expVec();
    int w;
    w = lowest(eff0());
    if (w == 2) return mOff[1] + 8'(lowest(mReq[1] & ~mMask[1]));
    return mOff[0] + 8'(w);
  endfunction

  task automatic chk(string tag, logic ok, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelStep(logic we, logic un, logic [1:0] sel, logic [7:0] d, logic ak);
    logic take[2];
    int   w[2];
    take[0] = ak && expReq();
    w[0] = lowest(eff0());
    w[1] = lowest(mReq[1] & ~mMask[1]);
    take[1] = take[0] && (w[0] == 2);
    for (int u = 0; u < 2; u++) begin
      logic [7:0] ln, r, isr, wb;
      ln  = (u == 1) ? curLines[15:8] : (curLines[7:0] & 8'hFB);
      r   = mReq[u] | ((ln & ~mPrev[u]) & ~mMask[u]);
      wb  = 8'(1) << w[u];
      if (take[u]) r = r & ~wb;
      isr = (we && un == 1'(u) && sel == 2'd2) ? 8'h00 : mIsr[u];
      if (take[u]) isr = isr | wb;
      if (we && un == 1'(u) && sel == 2'd1) begin
        r = r & ~d;
        mMask[u] = d;
      end
      if (we && un == 1'(u) && sel == 2'd0) begin
        mOff[u] = d;
        mArm[u] = 1'b1;
      end
      mReq[u]  = r;
      mIsr[u]  = isr;
      mPrev[u] = ln;
    end
  endtask

  task automatic cyc(string tag, logic we, logic un, logic [1:0] sel, logic [7:0] d, logic ak);
    @(negedge clk);
    chk(tag, intReq === expReq(), 32'(intReq), 32'(expReq()));
    if (expReq()) chk(tag, vector === expVec(), 32'(vector), 32'(expVec()));
    wrEn = we; wrUnit = un; wrSel = sel; wrData = d; intAck = ak; irqIn = curLines;
    modelStep(we, un, sel, d, ak);
  endtask

  task automatic idle(string tag);
    cyc(tag, 1'b0, 1'b0, 2'd3, 8'h00, 1'b0);
  endtask

  task automatic wr(string tag, logic un, logic [1:0] sel, logic [7:0] d);
    cyc(tag, 1'b1, un, sel, d, 1'b0);
  endtask

  task automatic ack(string tag);
    cyc(tag, 1'b0, 1'b0, 2'd3, 8'h00, 1'b1);
  endtask

  // checks outputs as of the last clock edge
  task automatic lit(string tag, logic r, logic [7:0] v);
    chk(tag, intReq === r, 32'(intReq), 32'(r));
    if (r) chk(tag, vector === v, 32'(vector), 32'(v));
  endtask

  initial begin
    #1500000;
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    for (int u = 0; u < 2; u++) begin
      mMask[u] = 8'hFF; mOff[u] = 0; mReq[u] = 0; mIsr[u] = 0; mPrev[u] = 0; mArm[u] = 0;
    end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    idle("R1"); lit("R1", 1'b0, 8'h00);

    // R2 arming order
    wr("R9", 1'b0, 2'd0, 8'd32);
    wr("R9", 1'b0, 2'd1, 8'h00);
    curLines[0] = 1'b1;
    idle("R2"); idle("R2"); lit("R2", 1'b0, 8'h00);
    wr("R2", 1'b1, 2'd0, 8'd40);
    idle("R2"); lit("R2", 1'b1, 8'd32);

    // R4 in-service blocking, level-held line
    curLines[1] = 1'b1;
    ack("R4"); idle("R4"); lit("R4", 1'b0, 8'h00);
    wr("R4", 1'b0, 2'd2, 8'h00); idle("R4"); lit("R4", 1'b1, 8'd33);
    ack("R4"); wr("R4", 1'b0, 2'd2, 8'h00); idle("R4"); lit("R4", 1'b0, 8'h00);

    // R3 masked edge dropped
    curLines[11] = 1'b1;
    idle("R3"); idle("R3"); lit("R3", 1'b0, 8'h00);
    wr("R3", 1'b1, 2'd1, 8'hF7); idle("R3"); lit("R3", 1'b0, 8'h00);

    // R7 cascade slot beats primary line 5
    curLines[11] = 1'b0; idle("R7");
    curLines[11] = 1'b1; curLines[5] = 1'b1;
    idle("R7"); idle("R7"); lit("R7", 1'b1, 8'd43);

    // R5 slave then master end-of-interrupt
    ack("R5"); idle("R5"); lit("R5", 1'b0, 8'h00);
    wr("R5", 1'b1, 2'd2, 8'h00); idle("R5"); lit("R5", 1'b0, 8'h00);
    wr("R5", 1'b0, 2'd2, 8'h00); idle("R5"); lit("R5", 1'b1, 8'd37);
    ack("R5"); wr("R5", 1'b0, 2'd2, 8'h00); idle("R5"); lit("R5", 1'b0, 8'h00);

    // R8 input bit 2 ignored
    curLines[2] = 1'b1;
    idle("R8"); idle("R8"); lit("R8", 1'b0, 8'h00);
    curLines[2] = 1'b0;

    // R5 master first, then slave
    curLines[11] = 1'b0; idle("R6");
    curLines[11] = 1'b1;
    idle("R6"); idle("R6"); lit("R6", 1'b1, 8'd43);
    ack("R5"); wr("R5", 1'b0, 2'd2, 8'h00); idle("R5"); lit("R5", 1'b0, 8'h00);
    wr("R5", 1'b1, 2'd2, 8'h00); idle("R5"); lit("R5", 1'b0, 8'h00);

    // R9 reserved select has no effect
    curLines[6] = 1'b1;
    wr("R9", 1'b0, 2'd3, 8'hFF); idle("R9"); lit("R9", 1'b1, 8'd38);
    ack("R9"); wr("R9", 1'b0, 2'd2, 8'h00);

    // R6 vector wrap
    wr("R6", 1'b0, 2'd0, 8'hFE);
    curLines[3] = 1'b1;
    idle("R6"); idle("R6"); lit("R6", 1'b1, 8'h01);
    ack("R6"); wr("R6", 1'b0, 2'd2, 8'h00);
    wr("R6", 1'b0, 2'd0, 8'd32);

    // random traffic against the reference
    for (int k = 0; k < 4000; k++) begin
      int a;
      if (($urandom % 100) < 12) begin
        int b;
        b = $urandom % 16;
        curLines[b] = ~curLines[b];
      end
      a = $urandom % 100;
      if (a < 25 && expReq()) ack("R7");
      else if (a < 37) wr("R4", 1'($urandom % 2), 2'd2, 8'h00);
      else if (a < 40) wr("R3", 1'($urandom % 2), 2'd1, (($urandom % 4) == 0) ? 8'($urandom) : 8'h00);
      else if (a < 41) wr("R6", 1'($urandom % 2), 2'd0, 8'($urandom));
      else idle("R7");
    end
    idle("R7");

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule